// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder-Subtractor

This block adds or subtracts two binary32 floating-point words: an accumulator value and a general register value. For subtraction it inverts the sign of the second operand before doing anything else, so every operation is an addition of two signed values. Each operand is first tagged with a three-bit kind code: zero 000, subnormal 001, normal 10x (the block emits 100), infinity 110, NaN 111. The two codes together steer the pair to one of four paths, and an output multiplexer takes the result from the active path.

Three paths do arithmetic. One handles two normal operands. One handles a normal operand paired with a subnormal one. One handles two subnormal operands, which share one exponent, so that sum is an exact integer add or subtract. A fourth, symbolic path resolves every pair that contains a zero, an infinity or a NaN without any arithmetic. In the two aligning paths the smaller operand is shifted to the larger exponent while the shifted-out bits are kept as guard, round and sticky bits. The magnitudes are then added or subtracted according to the signs, renormalised by a leading-zero shift that stops at the smallest exponent, and rounded to nearest with ties to even.

Operands enter through a valid/ready handshake. Each accepted operation yields exactly one result, registered one cycle after acceptance and held until the consumer takes it.

Top module: `fpadd_split`

## Requirements
- R1: Adding or subtracting two normal operands gives the correctly rounded sum; with `op_sub` = 1 the result is `acc_in` minus `gpr_in` (e.g. 2.0 - 3.0 = 0xBF800000).
- R2: Bits lost when the smaller operand is aligned or when the sum is renormalised are rounded to nearest, ties to even, including the case where rounding carries into the next exponent.
- R3: Pairs of two subnormal operands, or of a normal and a subnormal operand, give the exact or correctly rounded result. A result below the normal range is encoded with exponent field 0, and a carry into the hidden bit produces exponent field 1.
- R4: A sum whose magnitude exceeds the largest finite value, whether before or after rounding, returns an infinity with the sign of the result (exponent field all ones, fraction 0).
- R5: Any NaN operand returns the quiet NaN 0x7FC00000.
- R6: Infinities of opposite effective sign return 0x7FC00000. Infinities of equal sign return that infinity. An infinity plus a finite value returns the infinity.
- R7: A zero operand returns the other operand unchanged, with its effective sign. Two zeros of equal sign return that zero. An exact cancellation, or two zeros of opposite sign, returns +0 (0x00000000).
- R8: `in_ready` is high when no result is held or the held result is being taken. The result appears with `out_valid` one cycle after acceptance and stays unchanged while `out_ready` is low, and no new operand is accepted in that time.
- R9: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block can accept an operand pair |
| op_sub | input | 1 | 1: subtract `gpr_in` from `acc_in`; 0: add |
| acc_in | input | 32 | Accumulator operand, binary32 |
| gpr_in | input | 32 | General register operand, binary32 |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 32 | Sum or difference, binary32 |

## Verification
The hardest situations to reach from the ports are exact rounding ties at the far ends of alignment. One is a second operand exactly half an ulp below the first, where the guard bit alone decides and the even rule must pick between neighbours. The other is a subtraction whose borrow drops the sum below the leading bit, so that the renormalising shift pulls the guard bit into the fraction before rounding. Directed operand pairs are chosen by exponent arithmetic so that each tie, sticky-only alignment, rounding overflow to infinity and renormalisation that stops at the minimum exponent is hit exactly. Every expected value is worked out by hand from the binary expansion.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

   // Operand kind code; the normal code matches 10x, the block emits 100
   typedef enum logic [2:0] {
      FK_ZERO = 3'b000,
      FK_SUBN = 3'b001,
      FK_NORM = 3'b100,
      FK_INF  = 3'b110,
      FK_NAN  = 3'b111
   } fkind_e;

   typedef enum logic [1:0] {
      RP_NORM = 2'd0,
      RP_MIX  = 2'd1,
      RP_SUBN = 2'd2,
      RP_SYM  = 2'd3
   } rpath_e;

   function automatic logic kind_is_norm(input fkind_e k);
      return (k[2:1] == 2'b10) && (k[0] == 1'b0 || k[0] == 1'b1);
   endfunction

   function automatic logic kind_is_special(input fkind_e k);
      return (k == FK_ZERO) || (k == FK_INF) || (k == FK_NAN);
   endfunction

endpackage

// File: rtl/fpadd_classify.sv
module fpadd_classify
   import fpadd_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [EXP_W+MAN_W:0] op,
   output fkind_e               kind
);
   localparam int FW = 1 + EXP_W + MAN_W;

   logic [EXP_W-1:0] ex;
   logic [MAN_W-1:0] fr;

   assign ex = op[FW-2:MAN_W];
   assign fr = op[MAN_W-1:0];

   always_comb begin
      if (ex == '0)
         kind = (fr == '0) ? FK_ZERO : FK_SUBN;
      else if (ex == '1)
         kind = (fr == '0) ? FK_INF : FK_NAN;
      else
         kind = FK_NORM;
   end
endmodule

// File: rtl/fpadd_align_add.sv
module fpadd_align_add #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   parameter bit MIXED = 1'b0
) (
   input  logic [EXP_W+MAN_W:0] a_op,
   input  logic [EXP_W+MAN_W:0] b_op,
   output logic [EXP_W+MAN_W:0] sum_op
);
   localparam int FW = 1 + EXP_W + MAN_W;
   localparam int SW = MAN_W + 1;     // significand with hidden bit
   localparam int W  = SW + 3;        // plus guard, round, sticky
   localparam int EW = EXP_W + 2;     // internal exponent width
   localparam logic [EXP_W-1:0] EMAX = '1;

   logic [EXP_W-1:0] ea, eb, eh, el, d;
   logic [SW-1:0]    siga, sigb, sigh, sigl;
   logic             a_big, sgn, eff_sub;

   // variant: the mixed path treats a zero exponent field as 1 with no hidden bit
   if (MIXED) begin : g_mixed_unpack
      assign ea   = (a_op[FW-2:MAN_W] == '0) ? EXP_W'(1) : a_op[FW-2:MAN_W];
      assign eb   = (b_op[FW-2:MAN_W] == '0) ? EXP_W'(1) : b_op[FW-2:MAN_W];
      assign siga = {|a_op[FW-2:MAN_W], a_op[MAN_W-1:0]};
      assign sigb = {|b_op[FW-2:MAN_W], b_op[MAN_W-1:0]};
   end else begin : g_norm_unpack
      assign ea   = a_op[FW-2:MAN_W];
      assign eb   = b_op[FW-2:MAN_W];
      assign siga = {1'b1, a_op[MAN_W-1:0]};
      assign sigb = {1'b1, b_op[MAN_W-1:0]};
   end

   assign a_big   = {ea, siga} >= {eb, sigb};
   assign eh      = a_big ? ea : eb;
   assign el      = a_big ? eb : ea;
   assign sigh    = a_big ? siga : sigb;
   assign sigl    = a_big ? sigb : siga;
   assign sgn     = a_big ? a_op[FW-1] : b_op[FW-1];
   assign eff_sub = a_op[FW-1] ^ b_op[FW-1];
   assign d       = eh - el;

   logic [W-1:0] xl, al;
   logic [W:0]   raw;

   // alignment with the shifted-out bits folded into the sticky position
   always_comb begin
      xl = {sigl, 3'b000};
      if (32'(d) >= W) begin
         al    = '0;
         al[0] = |xl;
      end else begin
         al    = xl >> d;
         al[0] = al[0] | (|(xl & ~({W{1'b1}} << d)));
      end
   end

   assign raw = eff_sub ? ({1'b0, sigh, 3'b000} - {1'b0, al})
                        : ({1'b0, sigh, 3'b000} + {1'b0, al});

   logic [W-1:0]    m;
   logic [EW-1:0]   e, ef;
   logic [FW-2:0]   packed_r;
   logic            rnd;
   int              lz, room, sh;

   // renormalise: right by one on carry, else left by leading zeros,
   // never below the smallest exponent
   always_comb begin
      lz = W;
      for (int i = 0; i < W; i++)
         if (raw[i]) lz = W - 1 - i;
      room = int'(eh) - 1;
      sh   = (lz < room) ? lz : room;
      if (raw[W]) begin
         m    = raw[W:1];
         m[0] = raw[1] | raw[0];
         e    = EW'(eh) + EW'(1);
      end else begin
         m = raw[W-1:0] << sh;
         e = EW'(eh) - EW'(sh);
      end
      ef = m[W-1] ? e : '0;
   end

   assign rnd      = m[2] & (m[1] | m[0] | m[3]);
   assign packed_r = {ef[EXP_W-1:0], m[W-2:3]} + (FW-1)'(rnd);

   always_comb begin
      if (raw == '0)
         sum_op = '0;
      else if (ef >= EW'(EMAX))
         sum_op = {sgn, EMAX, {MAN_W{1'b0}}};
      else
         sum_op = {sgn, packed_r};
   end
endmodule

// File: rtl/fpadd_subn_path.sv
module fpadd_subn_path #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic             sa,
   input  logic [MAN_W-1:0] fa,
   input  logic             sb,
   input  logic [MAN_W-1:0] fb,
   output logic [EXP_W+MAN_W:0] res
);
   logic [MAN_W:0] mag;
   logic           sgn;

   // shared exponent: an exact integer add or subtract of the fractions
   always_comb begin
      if (sa == sb) begin
         mag = {1'b0, fa} + {1'b0, fb};
         sgn = sa;
      end else if (fa >= fb) begin
         mag = {1'b0, fa} - {1'b0, fb};
         sgn = sa;
      end else begin
         mag = {1'b0, fb} - {1'b0, fa};
         sgn = sb;
      end
      if (mag == '0) sgn = 1'b0;
   end

   // a carry into bit MAN_W lands in the exponent field as 1
   assign res = {sgn, {(EXP_W-1){1'b0}}, mag};
endmodule

// File: rtl/fpadd_symbolic.sv
module fpadd_symbolic
   import fpadd_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [EXP_W+MAN_W:0] a_op,
   input  logic [EXP_W+MAN_W:0] b_op,
   input  fkind_e               ka,
   input  fkind_e               kb,
   output logic [EXP_W+MAN_W:0] res
);
   localparam int FW = 1 + EXP_W + MAN_W;
   localparam logic [FW-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

   always_comb begin
      if (ka == FK_NAN || kb == FK_NAN)
         res = QNAN;
      else if (ka == FK_INF && kb == FK_INF)
         res = (a_op[FW-1] != b_op[FW-1]) ? QNAN : a_op;
      else if (ka == FK_INF)
         res = a_op;
      else if (kb == FK_INF)
         res = b_op;
      else if (ka == FK_ZERO && kb == FK_ZERO)
         res = (a_op[FW-1] == b_op[FW-1]) ? a_op : '0;
      else if (ka == FK_ZERO)
         res = b_op;
      else
         res = a_op;
   end
endmodule

// File: rtl/fpadd_split.sv
module fpadd_split
   import fpadd_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic                 op_sub,
   input  logic [EXP_W+MAN_W:0] acc_in,
   input  logic [EXP_W+MAN_W:0] gpr_in,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [EXP_W+MAN_W:0] result
);
   localparam int FW = 1 + EXP_W + MAN_W;
   localparam logic [FW-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

   if (EXP_W < 3 || MAN_W < 3) begin : g_bad_width
      $error("fpadd_split: EXP_W and MAN_W must each be at least 3");
   end

   logic [FW-1:0] ops [2];
   fkind_e        kinds [2];

   assign ops[0] = acc_in;
   assign ops[1] = {gpr_in[FW-1] ^ op_sub, gpr_in[FW-2:0]};

   for (genvar k = 0; k < 2; k++) begin : g_cls
      fpadd_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
         .op   (ops[k]),
         .kind (kinds[k])
      );
   end

   logic [FW-1:0] r_norm, r_mix, r_subn, r_sym, r_sel;
   rpath_e        path;

   fpadd_align_add #(.EXP_W(EXP_W), .MAN_W(MAN_W), .MIXED(1'b0)) u_norm (
      .a_op (ops[0]), .b_op (ops[1]), .sum_op (r_norm));

   fpadd_align_add #(.EXP_W(EXP_W), .MAN_W(MAN_W), .MIXED(1'b1)) u_mix (
      .a_op (ops[0]), .b_op (ops[1]), .sum_op (r_mix));

   fpadd_subn_path #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_subn (
      .sa (ops[0][FW-1]), .fa (ops[0][MAN_W-1:0]),
      .sb (ops[1][FW-1]), .fb (ops[1][MAN_W-1:0]),
      .res (r_subn));

   fpadd_symbolic #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_sym (
      .a_op (ops[0]), .b_op (ops[1]), .ka (kinds[0]), .kb (kinds[1]),
      .res (r_sym));

   // path decode from the two kind codes, then the output multiplexer
   always_comb begin
      if (kind_is_special(kinds[0]) || kind_is_special(kinds[1]))
         path = RP_SYM;
      else if (kind_is_norm(kinds[0]) && kind_is_norm(kinds[1]))
         path = RP_NORM;
      else if (kinds[0] == FK_SUBN && kinds[1] == FK_SUBN)
         path = RP_SUBN;
      else
         path = RP_MIX;
      case (path)
         RP_NORM: r_sel = r_norm;
         RP_MIX:  r_sel = r_mix;
         RP_SUBN: r_sel = r_subn;
         default: r_sel = r_sym;
      endcase
   end

   logic fire;
   assign in_ready = !out_valid || out_ready;
   assign fire     = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else if (fire) begin
         out_valid <= 1'b1;
         result    <= r_sel;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> out_valid);

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(result)));

   p_nan_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && (kinds[0] == FK_NAN || kinds[1] == FK_NAN)) |=> (result == QNAN));

   p_inf_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && kinds[0] == FK_INF && kinds[1] != FK_INF && kinds[1] != FK_NAN)
      |=> (result == {$past(acc_in[FW-1]), {EXP_W{1'b1}}, {MAN_W{1'b0}}}));

   p_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && kinds[0] != FK_NAN && kinds[0] != FK_INF &&
       ops[0] == {~ops[1][FW-1], ops[1][FW-2:0]}) |=> (result == '0));
endmodule

// File: tb/test_fpadd_split.sv
module test_fpadd_split;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic        op_sub = 1'b0;
   logic [31:0] acc_in = '0;
   logic [31:0] gpr_in = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [31:0] result;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   fpadd_split i_fpadd_split (
      .clk, .rst_n, .in_valid, .in_ready, .op_sub, .acc_in, .gpr_in,
      .out_valid, .out_ready, .result);

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // one operation: drive at a falling edge, accepted at the next rising edge,
   // registered result sampled at the following falling edge
   task automatic do_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                        input logic sub, input logic [31:0] exp);
      @(negedge clk);
      acc_in = a; gpr_in = b; op_sub = sub; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk({tag, " valid"}, {31'b0, out_valid}, 32'd1);
      chk(tag, result, exp);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R9 out_valid", {31'b0, out_valid}, 32'd0);
      chk("R9 in_ready", {31'b0, in_ready}, 32'd1);
      rst_n = 1'b1;
   endtask

   task automatic t_normal;
      do_op("R1 1+1",        32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000);
      do_op("R1 1.5+2.25",   32'h3FC00000, 32'h40100000, 1'b0, 32'h40700000);
      do_op("R1 2-3",        32'h40000000, 32'h40400000, 1'b1, 32'hBF800000);
      do_op("R1 1-(1-ulp)",  32'h3F800000, 32'h3F7FFFFF, 1'b1, 32'h33800000);
   endtask

   task automatic t_round;
      do_op("R2 tie even down", 32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000);
      do_op("R2 tie even up",   32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002);
      do_op("R2 above half",    32'h3F800000, 32'h33800001, 1'b0, 32'h3F800001);
      do_op("R2 sticky only",   32'h3F800000, 32'h30800000, 1'b0, 32'h3F800000);
      do_op("R2 borrow tie",    32'h3F800000, 32'h33000000, 1'b1, 32'h3F800000);
   endtask

   task automatic t_subnormal;
      do_op("R3 sub+sub",         32'h00000001, 32'h00000001, 1'b0, 32'h00000002);
      do_op("R3 carry to normal", 32'h00400000, 32'h00400000, 1'b0, 32'h00800000);
      do_op("R3 sub neg",         32'h00000003, 32'h00000005, 1'b1, 32'h80000002);
      do_op("R3 mixed to subn",   32'h00800000, 32'h00000001, 1'b1, 32'h007FFFFF);
      do_op("R3 mixed normal",    32'h00800000, 32'h00000001, 1'b0, 32'h00800001);
      do_op("R3 tiny lost",       32'h3F800000, 32'h00000001, 1'b0, 32'h3F800000);
      do_op("R3 normal to subn",  32'h00800001, 32'h00800000, 1'b1, 32'h00000001);
   endtask

   task automatic t_overflow;
      do_op("R4 max+max",      32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000);
      do_op("R4 neg overflow", 32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, 32'hFF800000);
      do_op("R4 round to inf", 32'h7F7FFFFF, 32'h73000000, 1'b0, 32'h7F800000);
   endtask

   task automatic t_nan;
      do_op("R5 nan a", 32'h7F800001, 32'h3F800000, 1'b0, 32'h7FC00000);
      do_op("R5 nan b", 32'h3F800000, 32'hFFC12345, 1'b1, 32'h7FC00000);
   endtask

   task automatic t_inf;
      do_op("R6 inf+1",      32'h7F800000, 32'h3F800000, 1'b0, 32'h7F800000);
      do_op("R6 inf-inf",    32'h7F800000, 32'h7F800000, 1'b1, 32'h7FC00000);
      do_op("R6 inf+-inf",   32'h7F800000, 32'hFF800000, 1'b0, 32'h7FC00000);
      do_op("R6 -inf+-inf",  32'hFF800000, 32'hFF800000, 1'b0, 32'hFF800000);
      do_op("R6 1-inf",      32'h3F800000, 32'h7F800000, 1'b1, 32'hFF800000);
   endtask

   task automatic t_zero;
      do_op("R7 0+x",      32'h00000000, 32'h3FC00000, 1'b0, 32'h3FC00000);
      do_op("R7 0-x",      32'h00000000, 32'h3FC00000, 1'b1, 32'hBFC00000);
      do_op("R7 x+0",      32'h00000007, 32'h80000000, 1'b0, 32'h00000007);
      do_op("R7 -0+-0",    32'h80000000, 32'h80000000, 1'b0, 32'h80000000);
      do_op("R7 -0++0",    32'h80000000, 32'h00000000, 1'b0, 32'h00000000);
      do_op("R7 -0-+0",    32'h80000000, 32'h00000000, 1'b1, 32'h80000000);
      do_op("R7 x-x",      32'h40490FDB, 32'h40490FDB, 1'b1, 32'h00000000);
      do_op("R7 subn-subn", 32'h00000005, 32'h00000005, 1'b1, 32'h00000000);
   endtask

   task automatic t_handshake;
      @(negedge clk);
      out_ready = 1'b0;
      acc_in = 32'h3F800000; gpr_in = 32'h3F800000; op_sub = 1'b0; in_valid = 1'b1;
      @(negedge clk);
      chk("R8 valid after accept", {31'b0, out_valid}, 32'd1);
      chk("R8 first result", result, 32'h40000000);
      chk("R8 ready low when full", {31'b0, in_ready}, 32'd0);
      acc_in = 32'h3FC00000; gpr_in = 32'h40100000;
      @(negedge clk);
      chk("R8 held valid", {31'b0, out_valid}, 32'd1);
      chk("R8 held result", result, 32'h40000000);
      out_ready = 1'b1;
      #1;
      chk("R8 ready on drain", {31'b0, in_ready}, 32'd1);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R8 second result", result, 32'h40700000);
      @(negedge clk);
      chk("R8 drained", {31'b0, out_valid}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_normal();
      t_round();
      t_subnormal();
      t_overflow();
      t_nan();
      t_inf();
      t_zero();
      t_handshake();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule